// File: doc/BRIEF.md
# Ethernet Receive Frame Error Sorter

This block sits at the tail of an Ethernet receive path. When the upstream logic signals that a frame has ended, or has been cut short, the block looks at four inputs:

- whether the receive FIFO overran,
- whether any receive buffer was free,
- the CRC verdict taken at the last full octet,
- how many stray bits followed that octet.

From these it picks exactly one outcome for the frame. On the next clock edge it raises the matching one-cycle pulses: the descriptor status bits, the event flags and a request to go back to hunting for a new frame. In the same edge it bumps one of three error counters.

Overrun and no-buffer losses both go into a single counter of discarded frames. Stray trailing bits are treated in one of two ways. With a good CRC they are forgiven silently. With a bad CRC the frame counts as an alignment error rather than a CRC error. The CRC verdict is always evaluated. Software that does not care about it simply disregards the CRC flag and counter.

When several conditions hold at once, only one is reported. The order is: missing buffer, then overrun, then misalignment, then CRC. Each counter saturates at all-ones and has its own clear input, driven by a host write.

Top module: `rx_err_sorter`

## Requirements
- R1: While and after reset, before any frame end, every pulse output is 0 and all three counters read 0.
- R2: A frame end with `noBuf`=1 gives `evBusy`=1, `evRxf`=0, `stOvr`=0, `stCrc`=0 and adds 1 to `cntDiscard`, whatever the other inputs are. Busy has the highest priority, so `evBusy`, `stOvr` and `stCrc` are never high together.
- R3: A frame end with `noBuf`=0 and `fifoOvr`=1 gives `stOvr`=1 and `evRxf`=1, adds 1 to `cntDiscard`, and leaves the other counters unchanged.
- R4: A frame end with no overrun, no busy, `dribbleBits` in 1..7 and `crcBad`=1 gives `evRxf`=1 and `stCrc`=0, adds 1 to `cntAlign`, and leaves `cntCrc` unchanged.
- R5: A frame end with no overrun, no busy, `dribbleBits` in 1..7 and `crcBad`=0 gives `evRxf`=1 only; no status bit is set and no counter changes.
- R6: A frame end with no overrun, no busy, `dribbleBits`=0 and `crcBad`=1 gives `stCrc`=1 and `evRxf`=1 and adds 1 to `cntCrc`.
- R7: A frame end with no overrun, no busy, `dribbleBits`=0 and `crcBad`=0 gives `evRxf`=1 only; no counter changes.
- R8: All pulse outputs are registered. They appear in the cycle after the `frameDone` cycle and last one cycle. Inputs sampled while `frameDone`=0 cause no pulse and no counter change.
- R9: `huntReq` pulses for every frame end, whatever the outcome.
- R10: Each counter is 16 bits wide and stays at 65535 when further increments arrive.
- R11: Driving a clear input high for one cycle makes that counter read 0 on the next cycle. A clear wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameDone | input | 1 | One-cycle strobe: the current frame has ended or was aborted |
| fifoOvr | input | 1 | Receive FIFO overran during the frame |
| noBuf | input | 1 | No receive buffer was available for the frame |
| crcBad | input | 1 | CRC mismatch judged at the last full octet |
| dribbleBits | input | 3 | Number of bits after the last full octet (0 means aligned) |
| clrDiscard | input | 1 | Host write: clear the discarded-frame counter |
| clrCrc | input | 1 | Host write: clear the CRC-error counter |
| clrAlign | input | 1 | Host write: clear the alignment-error counter |
| stOvr | output | 1 | Descriptor overrun bit pulse |
| stCrc | output | 1 | Descriptor CRC-error bit pulse |
| evRxf | output | 1 | Frame-received event pulse |
| evBusy | output | 1 | Busy (frame dropped for lack of buffer) event pulse |
| huntReq | output | 1 | Request to return the receiver to hunt mode |
| cntDiscard | output | 16 | Saturating count of frames dropped by overrun or busy |
| cntCrc | output | 16 | Saturating count of aligned frames with a bad CRC |
| cntAlign | output | 16 | Saturating count of misaligned frames with a bad CRC |

## Verification
Some rules hold in every cycle, and the checker watches them continuously:

- busy, overrun and CRC status are mutually exclusive;
- busy never comes with a received-frame event;
- an idle cycle is followed by silence;
- every frame end is followed by a hunt request;
- counters move by at most one per cycle, hold at all-ones and read zero after a clear.

Other behaviour only the bench scenarios can show: which outcome a given mix of overrun, buffer, CRC and dribble inputs selects, and which counter it lands in. The bench covers this by sweeping all 64 input combinations. It also checks the long run up to saturation and a clear issued in the same cycle as an increment.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

  localparam int NUM_CNT   = 3;
  localparam int IDX_DISC  = 0;
  localparam int IDX_CRC   = 1;
  localparam int IDX_ALIGN = 2;

  typedef enum logic [2:0] {
    OUT_NONE,
    OUT_BUSY,
    OUT_OVR,
    OUT_ALIGN,
    OUT_CRC,
    OUT_DRIB_OK,
    OUT_GOOD
  } rxOutcome_e;

  // strobes from control to datapath
  typedef struct packed {
    logic incDiscard;
    logic incCrc;
    logic incAlign;
  } rxStrobe_t;

  // registered per-frame pulses
  typedef struct packed {
    logic rxf;
    logic busy;
    logic ovr;
    logic crcErr;
    logic hunt;
  } rxStatus_t;

endpackage

// File: rtl/rx_sat_cnt.sv
module rx_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx_err_ctrl.sv
module rx_err_ctrl
  import rx_err_pkg::*;
#(
  parameter int DRIB_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic              fifoOvr,
  input  logic              noBuf,
  input  logic              crcBad,
  input  logic [DRIB_W-1:0] dribbleBits,
  output rxStrobe_t         strobe,
  output rxStatus_t         status
);
  rxOutcome_e outcome;
  rxStatus_t  nextStatus;
  logic       misaligned;

  assign misaligned = (dribbleBits != '0);

  // priority: busy, overrun, alignment, crc
  always_comb begin
    if (!frameDone)                outcome = OUT_NONE;
    else if (noBuf)                outcome = OUT_BUSY;
    else if (fifoOvr)              outcome = OUT_OVR;
    else if (misaligned && crcBad) outcome = OUT_ALIGN;
    else if (misaligned)           outcome = OUT_DRIB_OK;
    else if (crcBad)               outcome = OUT_CRC;
    else                           outcome = OUT_GOOD;
  end

  always_comb begin
    strobe     = '0;
    nextStatus = '0;
    unique case (outcome)
      OUT_BUSY: begin
        nextStatus.busy   = 1'b1;
        strobe.incDiscard = 1'b1;
      end
      OUT_OVR: begin
        nextStatus.ovr    = 1'b1;
        nextStatus.rxf    = 1'b1;
        strobe.incDiscard = 1'b1;
      end
      OUT_ALIGN: begin
        nextStatus.rxf  = 1'b1;
        strobe.incAlign = 1'b1;
      end
      OUT_CRC: begin
        nextStatus.crcErr = 1'b1;
        nextStatus.rxf    = 1'b1;
        strobe.incCrc     = 1'b1;
      end
      OUT_DRIB_OK, OUT_GOOD: nextStatus.rxf = 1'b1;
      default: ;
    endcase
    nextStatus.hunt = (outcome != OUT_NONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= nextStatus;
  end
endmodule

// File: rtl/rx_err_dp.sv
module rx_err_dp
  import rx_err_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strobe,
  input  logic             clrDiscard,
  input  logic             clrCrc,
  input  logic             clrAlign,
  output logic [CNT_W-1:0] cntDiscard,
  output logic [CNT_W-1:0] cntCrc,
  output logic [CNT_W-1:0] cntAlign
);
  logic [NUM_CNT-1:0] incVec;
  logic [NUM_CNT-1:0] clrVec;
  logic [CNT_W-1:0]   cntArr [NUM_CNT];

  always_comb begin
    incVec            = '0;
    clrVec            = '0;
    incVec[IDX_DISC]  = strobe.incDiscard;
    incVec[IDX_CRC]   = strobe.incCrc;
    incVec[IDX_ALIGN] = strobe.incAlign;
    clrVec[IDX_DISC]  = clrDiscard;
    clrVec[IDX_CRC]   = clrCrc;
    clrVec[IDX_ALIGN] = clrAlign;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    rx_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rstN(rstN),
      .inc (incVec[i]),
      .clr (clrVec[i]),
      .cnt (cntArr[i])
    );
  end

  assign cntDiscard = cntArr[IDX_DISC];
  assign cntCrc     = cntArr[IDX_CRC];
  assign cntAlign   = cntArr[IDX_ALIGN];
endmodule

// File: rtl/rx_err_sorter.sv
module rx_err_sorter
  import rx_err_pkg::*;
#(
  parameter int DRIB_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic              fifoOvr,
  input  logic              noBuf,
  input  logic              crcBad,
  input  logic [DRIB_W-1:0] dribbleBits,
  input  logic              clrDiscard,
  input  logic              clrCrc,
  input  logic              clrAlign,
  output logic              stOvr,
  output logic              stCrc,
  output logic              evRxf,
  output logic              evBusy,
  output logic              huntReq,
  output logic [CNT_W-1:0]  cntDiscard,
  output logic [CNT_W-1:0]  cntCrc,
  output logic [CNT_W-1:0]  cntAlign
);
  rxStrobe_t strobe;
  rxStatus_t status;

  rx_err_ctrl #(.DRIB_W(DRIB_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameDone  (frameDone),
    .fifoOvr    (fifoOvr),
    .noBuf      (noBuf),
    .crcBad     (crcBad),
    .dribbleBits(dribbleBits),
    .strobe     (strobe),
    .status     (status)
  );

  rx_err_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .clrDiscard(clrDiscard),
    .clrCrc    (clrCrc),
    .clrAlign  (clrAlign),
    .cntDiscard(cntDiscard),
    .cntCrc    (cntCrc),
    .cntAlign  (cntAlign)
  );

  assign stOvr   = status.ovr;
  assign stCrc   = status.crcErr;
  assign evRxf   = status.rxf;
  assign evBusy  = status.busy;
  assign huntReq = status.hunt;
endmodule

// File: rtl/rx_err_sorter_chk.sv
module rx_err_sorter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameDone,
  input logic             clrDiscard,
  input logic             clrCrc,
  input logic             clrAlign,
  input logic             stOvr,
  input logic             stCrc,
  input logic             evRxf,
  input logic             evBusy,
  input logic             huntReq,
  input logic [CNT_W-1:0] cntDiscard,
  input logic [CNT_W-1:0] cntCrc,
  input logic [CNT_W-1:0] cntAlign
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evBusy, stOvr, stCrc}));

  // R2
  busy_no_rxf_chk: assert property (@(posedge clk) disable iff (!rstN)
    evBusy |-> !evRxf);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> !(evRxf || evBusy || stOvr || stCrc || huntReq));

  // R9
  hunt_each_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> huntReq);

  // R10
  disc_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntDiscard == TOP && !clrDiscard) |=> cntDiscard == TOP);

  // R10
  crc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrCrc |=> (cntCrc == $past(cntCrc) || cntCrc == $past(cntCrc) + 1'b1));

  // R11
  align_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrAlign |=> cntAlign == '0);

  // R11
  disc_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrDiscard |=> cntDiscard == '0);
endmodule

bind rx_err_sorter rx_err_sorter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameDone (frameDone),
  .clrDiscard(clrDiscard),
  .clrCrc    (clrCrc),
  .clrAlign  (clrAlign),
  .stOvr     (stOvr),
  .stCrc     (stCrc),
  .evRxf     (evRxf),
  .evBusy    (evBusy),
  .huntReq   (huntReq),
  .cntDiscard(cntDiscard),
  .cntCrc    (cntCrc),
  .cntAlign  (cntAlign)
);

// File: tb/rx_err_sorter_tb.sv
`timescale 1ns/1ps
module rx_err_sorter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameDone = 0, fifoOvr = 0, noBuf = 0, crcBad = 0;
  logic [2:0] dribbleBits = '0;
  logic clrDiscard = 0, clrCrc = 0, clrAlign = 0;
  logic stOvr, stCrc, evRxf, evBusy, huntReq;
  logic [15:0] cntDiscard, cntCrc, cntAlign;

  int checks = 0;
  int errors = 0;
  int expDisc = 0, expCrc = 0, expAlign = 0;

  always #5 clk = ~clk;

  rx_err_sorter u_dut (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .fifoOvr(fifoOvr),
    .noBuf(noBuf), .crcBad(crcBad), .dribbleBits(dribbleBits),
    .clrDiscard(clrDiscard), .clrCrc(clrCrc), .clrAlign(clrAlign),
    .stOvr(stOvr), .stCrc(stCrc), .evRxf(evRxf), .evBusy(evBusy),
    .huntReq(huntReq), .cntDiscard(cntDiscard), .cntCrc(cntCrc),
    .cntAlign(cntAlign));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  // pulses {evRxf, evBusy, stOvr, stCrc, huntReq} then three counters
  function automatic logic [63:0] obs();
    return {11'd0, evRxf, evBusy, stOvr, stCrc, huntReq, cntDiscard, cntCrc, cntAlign};
  endfunction

  function automatic logic [63:0] pack(input logic [4:0] p, input int d, input int c, input int a);
    return {11'd0, p, d[15:0], c[15:0], a[15:0]};
  endfunction

  task automatic doFrame(input logic nb, input logic ov, input logic cb, input logic [2:0] dr);
    logic [4:0] p;
    string tag;
    noBuf = nb; fifoOvr = ov; crcBad = cb; dribbleBits = dr; frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
    if (nb)             begin p = 5'b01001; expDisc  = sat(expDisc + 1);  tag = "R2 busy"; end
    else if (ov)        begin p = 5'b10101; expDisc  = sat(expDisc + 1);  tag = "R3 overrun"; end
    else if (dr != 0 && cb) begin p = 5'b10001; expAlign = sat(expAlign + 1); tag = "R4 align"; end
    else if (dr != 0)   begin p = 5'b10001; tag = "R5 dribble ok"; end
    else if (cb)        begin p = 5'b10011; expCrc   = sat(expCrc + 1);   tag = "R6 crc"; end
    else                begin p = 5'b10001; tag = "R7 good"; end
    chk({tag, " R9"}, obs(), pack(p, expDisc, expCrc, expAlign));
  endtask

  task automatic idleCheck();
    noBuf = 1; fifoOvr = 1; crcBad = 1; dribbleBits = 3'd5; frameDone = 0;
    @(negedge clk);
    chk("R8 idle ignored", obs(), pack(5'b0, expDisc, expCrc, expAlign));
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", obs(), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", obs(), 64'd0);

    // full sweep of input combinations
    for (int i = 0; i < 64; i++) begin
      doFrame(i[5], i[4], i[3], i[2:0]);
      idleCheck();
    end

    // back-to-back frames: one-cycle pulses each
    doFrame(0, 0, 1, 3'd0);
    doFrame(0, 0, 1, 3'd2);
    doFrame(1, 1, 1, 3'd7);

    // R11 clears, and clear beats increment
    clrCrc = 1; @(negedge clk); clrCrc = 0; expCrc = 0;
    chk("R11 clear crc", {48'd0, cntCrc}, 64'd0);
    clrAlign = 1; clrDiscard = 1;
    noBuf = 1; frameDone = 1;
    @(negedge clk);
    frameDone = 0; noBuf = 0; clrAlign = 0; clrDiscard = 0;
    expAlign = 0; expDisc = 0;
    chk("R11 clear wins", obs(), pack(5'b01001, 0, 0, 0));

    // R10 saturation of discard counter
    noBuf = 1; frameDone = 1;
    repeat (65540) @(negedge clk);
    frameDone = 0; noBuf = 0;
    expDisc = 65535;
    @(negedge clk);
    chk("R10 saturate discard", {48'd0, cntDiscard}, 64'd65535);
    doFrame(0, 1, 0, 3'd0);
    chk("R10 stays saturated", {48'd0, cntDiscard}, 64'd65535);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule